// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port Controller

This block connects an internal requester to external memories and peripherals over a 16-bit bus. The same pins carry the address and the data, one after the other. A request is one read or one write of a single word. It is handed over with a valid/ready handshake that carries the direction, a 24-bit address and the write data. The block then runs a fixed bus sequence: one or two address cycles with the latch-enable high, then one cycle with the read or write strobe low. When a transfer ends, a one-cycle response pulse returns the sampled read data.

A mode input selects the external device width, and it is sampled when a request is accepted. In 16-bit mode a single address cycle carries the low 16 address bits, and data uses all 16 lanes. In 8-bit mode the address reach grows to 24 bits. A first address cycle places the upper 8 address bits on the low byte lane, and a second cycle places the low 16 bits. Data then travels only on the low byte lane, and the upper lane stays undriven. The bus pins are modelled as separate output, per-byte-lane output-enable and input vectors, so the chip's pad ring can form the tri-state.

Top module: `ppi_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, ale_o is 0, rd_no and wr_no are 1, bus_oe_o is 0 and rsp_valid_o is 0.
- R2: A request is accepted only on a rising edge with req_valid_i and req_ready_o both high. req_ready_o is 0 from the cycle after acceptance until the strobe cycle has ended. While req_valid_i is low in idle, the control outputs stay inactive.
- R3: In 16-bit mode (mode16_i=1) exactly one address cycle follows acceptance. In it, ale_o=1, bus_ad_o equals addr[15:0], and both lanes are enabled. addr[23:16] has no effect on the bus.
- R4: In 8-bit mode (mode16_i=0) two address cycles with ale_o=1 follow acceptance. The first drives bus_ad_o = {8'h00, addr[23:16]}. The second drives addr[15:0]. Both lanes are enabled in both cycles.
- R5: A write holds wr_no low for exactly one cycle, right after the last address cycle. In 16-bit mode, bus_ad_o equals the write data and bus_oe_o=2'b11. In 8-bit mode, bus_ad_o[7:0] equals wdata[7:0] and bus_oe_o=2'b01. Bit 0 of bus_oe_o enables AD[7:0], and bit 1 enables AD[15:8].
- R6: A read holds rd_no low for exactly one cycle with bus_oe_o=0. bus_ad_i is sampled on the rising edge that ends the strobe. In the next cycle rsp_valid_o=1 for one cycle, and rsp_rdata_o equals bus_ad_i (16-bit mode) or {8'h00, bus_ad_i[7:0]} (8-bit mode).
- R7: A write also ends with a one-cycle rsp_valid_o pulse in the cycle after the strobe. rsp_rdata_o keeps its previous value.
- R8: The cycle after the strobe is idle, with the bus undriven and req_ready_o=1. Back-to-back requests therefore start every 3 cycles in 16-bit mode and every 4 cycles in 8-bit mode.
- R9: ale_o, a low rd_no and a low wr_no never occur in the same cycle.
- R10: Mode, direction, address and write data are captured at acceptance. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request may be accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Request address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle transfer completion pulse |
| rsp_rdata_o | output | 16 | Read data of the last read |
| bus_ad_o | output | 16 | Multiplexed address/data out |
| bus_oe_o | output | 2 | Output enable per byte lane |
| bus_ad_i | input | 16 | Multiplexed bus in |
| ale_o | output | 1 | Address latch enable, active high |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the external device places stable read data on bus_ad_i during the strobe cycle. They also assume that the requester's inputs are only meaningful at acceptance. The stimulus drives bus_ad_i only at the negative edge inside the read strobe cycle, and it changes mode and request fields at random after acceptance to check that they are ignored. Requests are issued back to back, in a random mix of widths, directions, addresses and data, so the idle cycle between transfers is always exercised.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  parameter int unsigned AD_W   = 16;
  parameter int unsigned ADDR_W = 24;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = AD_W / BYTE_W;
  localparam int unsigned HI_W   = ADDR_W - AD_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_AHI  = 2'd1,
    ST_ALO  = 2'd2,
    ST_STRB = 2'd3
  } ppi_state_e;

  typedef struct packed {
    logic              wide;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [AD_W-1:0]   wdata;
  } ppi_req_t;
endpackage

// File: rtl/ppi_req_reg.sv
module ppi_req_reg
  import ppi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  ppi_req_t req_i,
  output ppi_req_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= req_i;
  end
endmodule

// File: rtl/ppi_seq.sv
module ppi_seq
  import ppi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wide_i,
  output ppi_state_e state_o
);
  ppi_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (start_i) state_d = wide_i ? ST_ALO : ST_AHI;
      ST_AHI:  state_d = ST_ALO;
      ST_ALO:  state_d = ST_STRB;
      ST_STRB: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/ppi_pins.sv
module ppi_pins
  import ppi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ppi_state_e       state_i,
  input  ppi_req_t         req_i,
  input  logic [AD_W-1:0]  bus_ad_i,
  output logic [AD_W-1:0]  bus_ad_o,
  output logic [LANES-1:0] bus_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             rsp_valid_o,
  output logic [AD_W-1:0]  rsp_rdata_o
);
  logic addr_ph, strb_ph;

  assign addr_ph = (state_i == ST_AHI) || (state_i == ST_ALO);
  assign strb_ph = (state_i == ST_STRB);
  assign ale_o   = addr_ph;
  assign rd_no   = !(strb_ph && !req_i.we);
  assign wr_no   = !(strb_ph && req_i.we);

  always_comb begin
    unique case (state_i)
      ST_AHI:  bus_ad_o = AD_W'(req_i.addr[ADDR_W-1:AD_W]);
      ST_ALO:  bus_ad_o = req_i.addr[AD_W-1:0];
      ST_STRB: bus_ad_o = req_i.we ? req_i.wdata : '0;
      default: bus_ad_o = '0;
    endcase
  end

  // lane 0 always carries data; upper lanes only for 16-bit devices
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign bus_oe_o[g] = addr_ph || (strb_ph && req_i.we);
    end else begin : g_up
      assign bus_oe_o[g] = addr_ph || (strb_ph && req_i.we && req_i.wide);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= strb_ph;
      if (strb_ph && !req_i.we)
        rsp_rdata_o <= req_i.wide ? bus_ad_i : AD_W'(bus_ad_i[BYTE_W-1:0]);
    end
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [AD_W-1:0]   req_wdata_i,
  output logic              rsp_valid_o,
  output logic [AD_W-1:0]   rsp_rdata_o,
  output logic [AD_W-1:0]   bus_ad_o,
  output logic [LANES-1:0]  bus_oe_o,
  input  logic [AD_W-1:0]   bus_ad_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no
);
  ppi_state_e state;
  ppi_req_t   req_d, req_q;
  logic       start;

  assign req_ready_o = (state == ST_IDLE);
  assign start       = req_valid_i && req_ready_o;
  assign req_d       = '{wide: mode16_i, we: req_we_i, addr: req_addr_i, wdata: req_wdata_i};

  ppi_req_reg u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .req_i  (req_d),
    .q_o    (req_q)
  );

  ppi_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .wide_i  (mode16_i),
    .state_o (state)
  );

  ppi_pins u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .req_i       (req_q),
    .bus_ad_i    (bus_ad_i),
    .bus_ad_o    (bus_ad_o),
    .bus_oe_o    (bus_oe_o),
    .ale_o       (ale_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/ppi_ctrl_chk.sv
module ppi_ctrl_chk
  import ppi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode16_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [AD_W-1:0]   req_wdata_i,
  input logic              rsp_valid_o,
  input logic [AD_W-1:0]   rsp_rdata_o,
  input logic [AD_W-1:0]   bus_ad_o,
  input logic [LANES-1:0]  bus_oe_o,
  input logic [AD_W-1:0]   bus_ad_i,
  input logic              ale_o,
  input logic              rd_no,
  input logic              wr_no
);
  // R9
  ctrl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, !rd_no, !wr_no}));

  // R6
  rd_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (bus_oe_o == '0));

  // R2
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o || !rd_no || !wr_no) |-> !req_ready_o);

  // R2
  accept_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ale_o);

  // R5
  strobe_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |=> (rd_no && wr_no && rsp_valid_o && req_ready_o));

  // R8
  idle_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bus_oe_o == '0));

  // R4
  two_addr_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && $past(ale_o)) |=> !ale_o);
endmodule

bind ppi_ctrl ppi_ctrl_chk chk_i (.*);

// File: tb/ppi_ctrl_tb_top.sv
module ppi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b1;
  logic        valid = 1'b0;
  logic        ready;
  logic        we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wd = '0;
  logic        rvalid;
  logic [15:0] rdata;
  logic [15:0] ad_o;
  logic [1:0]  oe;
  logic [15:0] ad_i = '0;
  logic        ale, rd_n, wr_n;

  int checks = 0;
  int fails = 0;
  logic [15:0] model_rdata = '0;
  bit done = 0;

  always #10 clk = ~clk;

  ppi_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode16_i(mode16),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wd),
    .rsp_valid_o(rvalid), .rsp_rdata_o(rdata),
    .bus_ad_o(ad_o), .bus_oe_o(oe), .bus_ad_i(ad_i),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input bit wide, input logic [15:0] bus);
    return wide ? bus : {8'h00, bus[7:0]};
  endfunction

  // called at a negedge with the controller idle
  task automatic xfer(input bit wide, input bit w, input logic [23:0] a,
                      input logic [15:0] d, input logic [15:0] rbus, input bit scramble);
    int cyc;
    mode16 = wide; we = w; addr = a; wd = d; valid = 1'b1;
    chk(ready === 1'b1, "R2 ready before accept", 32'(ready), 1);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (scramble) begin  // R10
      mode16 = ~wide; we = ~w; addr = 24'($urandom); wd = 16'($urandom);
    end
    cyc = 1;
    chk(ready === 1'b0, "R2 busy after accept", 32'(ready), 0);
    if (!wide) begin
      chk(ale === 1'b1 && oe === 2'b11, "R4 first addr cycle ctrl", {ale, oe}, 3'b111);
      chk(ad_o === {8'h00, a[23:16]}, "R4 upper address", ad_o, {8'h00, a[23:16]});
      @(negedge clk); cyc++;
    end
    chk(ale === 1'b1 && oe === 2'b11 && rd_n && wr_n,
        wide ? "R3 addr cycle ctrl" : "R4 second addr ctrl", {ale, oe, rd_n, wr_n}, 5'b11111);
    chk(ad_o === a[15:0], wide ? "R3 address" : "R4 lower address", ad_o, a[15:0]);
    @(negedge clk); cyc++;
    chk(ale === 1'b0 && ready === 1'b0, "R9 no ale in strobe", {ale, ready}, 0);
    if (w) begin
      chk(wr_n === 1'b0 && rd_n === 1'b1, "R5 write strobe", {rd_n, wr_n}, 2'b10);
      chk(oe === (wide ? 2'b11 : 2'b01), "R5 lane enables", oe, wide ? 2'b11 : 2'b01);
      if (wide) chk(ad_o === d, "R5 write data 16", ad_o, d);
      else      chk(ad_o[7:0] === d[7:0], "R5 write data 8", ad_o[7:0], d[7:0]);
    end else begin
      chk(rd_n === 1'b0 && wr_n === 1'b1, "R6 read strobe", {rd_n, wr_n}, 2'b01);
      chk(oe === 2'b00, "R6 bus released", oe, 0);
      ad_i = rbus;
    end
    @(negedge clk); cyc++;
    ad_i = 16'($urandom);
    chk(rd_n && wr_n && !ale && oe === 2'b00, "R8 idle after strobe", {rd_n, wr_n, ale, oe}, 5'b11000);
    chk(ready === 1'b1 && rvalid === 1'b1, "R6 R7 completion pulse", {ready, rvalid}, 2'b11);
    chk(cyc == (wide ? 3 : 4), "R8 cadence", cyc, wide ? 3 : 4);
    if (!w) begin
      model_rdata = exp_rd(wide, rbus);
      chk(rdata === model_rdata, "R6 read data", rdata, model_rdata);
    end else begin
      chk(rdata === model_rdata, "R7 rdata held on write", rdata, model_rdata);
    end
    mode16 = wide;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    chk(ready === 1'b1 && ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1 && oe === 2'b00 && rvalid === 1'b0,
        "R1 reset state", {ready, ale, rd_n, wr_n, oe, rvalid}, 7'b1011000);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!ale && rd_n && wr_n && !rvalid, "R2 idle without request", {ale, rd_n, wr_n, rvalid}, 4'b0110);
    end
    // directed corners
    xfer(1'b1, 1'b1, 24'hFF_1234, 16'hBEEF, 16'h0000, 1'b0);  // R3 upper ignored
    xfer(1'b1, 1'b0, 24'hA5_8001, 16'h0000, 16'hC3A5, 1'b0);
    xfer(1'b0, 1'b1, 24'hAB_CDEF, 16'h77E1, 16'h0000, 1'b0);
    xfer(1'b0, 1'b0, 24'hFF_FFFF, 16'h0000, 16'hDE5A, 1'b0);  // R6 upper byte dropped
    xfer(1'b0, 1'b1, 24'h00_0000, 16'hFFFF, 16'h0000, 1'b0);  // R7 rdata held
    xfer(1'b1, 1'b0, 24'h12_3456, 16'h0000, 16'h9876, 1'b1);  // R10
    xfer(1'b0, 1'b1, 24'h5A_0F0F, 16'h1234, 16'h0000, 1'b1);  // R10
    for (int i = 0; i < 300; i++) begin
      xfer(1'($urandom), 1'($urandom), 24'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        chk(!ale && rd_n && wr_n && ready, "R2 gap idle", {ale, rd_n, wr_n, ready}, 4'b0111);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule